// File: doc/BRIEF.md
# Context-Tagged Fully Associative Translation Buffer

This block caches virtual-to-physical page translations for a processor's memory pipeline. Each slot records a virtual page base, a page-size code, a physical frame, an address-space tag, a domain number, permission bits, an execute-never flag, a section flag and a non-cacheable flag. A requester presents a virtual address and an address-space tag. In the same cycle it gets back a hit indication, the slot that matched, that slot's attribute fields and the translated physical address. A miss is only reported. Walking the page tables and checking permissions are left to the requester.

New translations are written through an insert port into the slot chosen by a single replacement pointer. The pointer moves forward on every insert. It also moves forward when a lookup hits the slot it currently points at, so that an entry in active use is not the next one evicted. A flush port offers four invalidate modes: everything, by address-space tag, by address range regardless of tag, and by address together with tag.

Top module: `ctx_tlb`

## Requirements
- R1: A lookup with `lk_valid` high reports `lk_hit` only when some slot is valid, has a tag equal to `lk_ctx`, and covers `lk_va` under that slot's page size. A lookup with no such slot reports a miss.
- R2: When several slots match a lookup, the lowest-numbered slot is returned on `lk_slot` and its fields drive the outputs.
- R3: Size code 0, 1, 2 and 3 selects a page of 4 KiB, 64 KiB, 1 MiB or 16 MiB, that is an offset width of 12, 16, 20 or 24 bits. `lk_pa` takes its bits above the offset from the frame number (frame shifted left by 12) and its offset bits from `lk_va`.
- R4: An accepted insert writes the slot named by the replacement pointer, even if that slot is valid. The pointer then advances by one and wraps from the last slot to slot 0.
- R5: A lookup hit on the slot the pointer names advances the pointer. When an accepted insert and such a hit happen in the same cycle, the pointer advances only once.
- R6: A flush request takes priority over an insert in the same cycle, and that insert is dropped. `fl_done` is high for exactly the one cycle after each flush request. A flush other than flush-all leaves the pointer unchanged.
- R7: Flush op 0 invalidates every slot and returns the pointer to slot 0.
- R8: Flush op 1 invalidates every slot whose tag equals `fl_ctx`.
- R9: Flush op 2 invalidates every slot whose page range, from its base up to but not including base plus page size, contains `fl_va`, whatever its tag.
- R10: Flush op 3 invalidates every slot that a lookup of `fl_va` with tag `fl_ctx` would match, including duplicates.
- R11: After reset every slot is invalid, the pointer names slot 0 and `fl_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_ctx | input | 8 | Lookup address-space tag |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_slot | output | 4 | Index of the winning slot |
| lk_pa | output | 32 | Translated physical address |
| lk_size | output | 2 | Page-size code of the hit slot |
| lk_domain | output | 4 | Domain of the hit slot |
| lk_ap | output | 3 | Permission bits of the hit slot |
| lk_xn | output | 1 | Execute-never of the hit slot |
| lk_section | output | 1 | Section flag of the hit slot |
| lk_nc | output | 1 | Non-cacheable flag of the hit slot |
| ins_valid | input | 1 | Insert request |
| ins_vpn | input | 20 | Virtual page number (address bits 31:12) |
| ins_ctx | input | 8 | Address-space tag for the new entry |
| ins_size | input | 2 | Page-size code for the new entry |
| ins_pfn | input | 20 | Physical frame number |
| ins_domain | input | 4 | Domain number |
| ins_ap | input | 3 | Permission bits |
| ins_xn | input | 1 | Execute-never flag |
| ins_section | input | 1 | Section flag |
| ins_nc | input | 1 | Non-cacheable flag |
| fl_valid | input | 1 | Flush request |
| fl_op | input | 2 | Flush mode: 0 all, 1 tag, 2 address, 3 address and tag |
| fl_va | input | 32 | Flush address |
| fl_ctx | input | 8 | Flush tag |
| fl_done | output | 1 | One-cycle flush completion pulse |

## Verification
The bench fills all sixteen slots so that the pointer wraps. It then looks up the pointed slot, both alone and in the same cycle as an insert. A pointer that ignored hits, or that stepped twice, would send the next insert to the wrong slot, and that shows on `lk_slot`. It overlaps a large page with a smaller one that sits at a higher slot, so a priority encoder that favoured high indexes would return the wrong slot and address. It also checks physical-address stitching at every page size, and fires an address flush at the first byte past a 1 MiB page, so an inclusive range end would wrongly evict that page. Finally it issues a flush together with an insert: a design without flush priority would install the dropped entry or move the pointer.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 32;
  localparam int PG_LSB = 12;
  localparam int ASID_W = 8;
  localparam int DOM_W  = 4;
  localparam int AP_W   = 3;
  localparam int SZ_W   = 2;
  localparam int VPN_W  = VA_W - PG_LSB;
  localparam int PFN_W  = PA_W - PG_LSB;

  typedef enum logic [1:0] {
    FL_ALL       = 2'd0,
    FL_ASID      = 2'd1,
    FL_ADDR      = 2'd2,
    FL_ADDR_ASID = 2'd3
  } flush_op_e;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [SZ_W-1:0]   size;
    logic [PFN_W-1:0]  pfn;
    logic [ASID_W-1:0] asid;
    logic [DOM_W-1:0]  dom;
    logic [AP_W-1:0]   ap;
    logic              xn;
    logic              section;
    logic              nc;
  } tlb_entry_t;

  // offset width for a page-size code: 12, 16, 20, 24
  function automatic int size_shift(logic [SZ_W-1:0] sz);
    return PG_LSB + 4 * int'(sz);
  endfunction

  function automatic logic [VA_W-1:0] va_hi_mask(logic [SZ_W-1:0] sz);
    return {VA_W{1'b1}} << size_shift(sz);
  endfunction

  function automatic logic [PA_W-1:0] pa_hi_mask(logic [SZ_W-1:0] sz);
    return {PA_W{1'b1}} << size_shift(sz);
  endfunction

  // true when va lies inside the page described by e (tag/valid not considered)
  function automatic logic covers(tlb_entry_t e, logic [VA_W-1:0] va);
    logic [VA_W-1:0] m;
    m = va_hi_mask(e.size);
    return (({e.vpn, {PG_LSB{1'b0}}} & m) == (va & m));
  endfunction

  function automatic logic [PA_W-1:0] xlate(tlb_entry_t e, logic [VA_W-1:0] va);
    logic [PA_W-1:0] pm;
    pm = pa_hi_mask(e.size);
    return ({e.pfn, {PG_LSB{1'b0}}} & pm) | (PA_W'(va) & ~pm);
  endfunction
endpackage

// File: rtl/ctx_tlb_match.sv
module ctx_tlb_match
  import ctx_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  tlb_entry_t             ents [N_ENTRIES],
  input  logic [VA_W-1:0]        lk_va,
  input  logic [ASID_W-1:0]      lk_ctx,
  input  flush_op_e              fl_op,
  input  logic [VA_W-1:0]        fl_va,
  input  logic [ASID_W-1:0]      fl_ctx,
  output logic [N_ENTRIES-1:0]   lk_vec,
  output logic [N_ENTRIES-1:0]   fl_vec
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    always_comb begin
      lk_vec[g] = ents[g].valid && (ents[g].asid == lk_ctx) && covers(ents[g], lk_va);
      unique case (fl_op)
        FL_ALL:       fl_vec[g] = 1'b1;
        FL_ASID:      fl_vec[g] = (ents[g].asid == fl_ctx);
        FL_ADDR:      fl_vec[g] = covers(ents[g], fl_va);
        FL_ADDR_ASID: fl_vec[g] = ents[g].valid && (ents[g].asid == fl_ctx)
                                  && covers(ents[g], fl_va);
        default:      fl_vec[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ctx_tlb_pick.sv
module ctx_tlb_pick #(
  parameter int N_ENTRIES = 16,
  localparam int IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES-1:0] vec,
  output logic                 any,
  output logic [IW-1:0]        idx
);
  // lowest set bit wins: scan downward so the last assignment is the lowest index
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
  parameter int N_ENTRIES = 16,
  localparam int IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  localparam logic [IW-1:0] LAST = IW'(N_ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (clr) ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ptr == LAST) |=> (ptr == '0));

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(ptr));
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import ctx_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_ctx,
  output logic              lk_hit,
  output logic [IW-1:0]     lk_slot,
  output logic [PA_W-1:0]   lk_pa,
  output logic [SZ_W-1:0]   lk_size,
  output logic [DOM_W-1:0]  lk_domain,
  output logic [AP_W-1:0]   lk_ap,
  output logic              lk_xn,
  output logic              lk_section,
  output logic              lk_nc,
  input  logic              ins_valid,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [ASID_W-1:0] ins_ctx,
  input  logic [SZ_W-1:0]   ins_size,
  input  logic [PFN_W-1:0]  ins_pfn,
  input  logic [DOM_W-1:0]  ins_domain,
  input  logic [AP_W-1:0]   ins_ap,
  input  logic              ins_xn,
  input  logic              ins_section,
  input  logic              ins_nc,
  input  logic              fl_valid,
  input  logic [1:0]        fl_op,
  input  logic [VA_W-1:0]   fl_va,
  input  logic [ASID_W-1:0] fl_ctx,
  output logic              fl_done
);
  tlb_entry_t             ents [N_ENTRIES];
  tlb_entry_t             new_ent;
  tlb_entry_t             sel;
  flush_op_e              op_e;
  logic [N_ENTRIES-1:0]   lk_vec, fl_vec, valid_vec;
  logic                   lk_any;
  logic [IW-1:0]          vptr;
  // named internal events
  logic                   ins_fire, hit_on_ptr, ptr_adv, ptr_clr;

  assign op_e = flush_op_e'(fl_op);

  ctx_tlb_match #(.N_ENTRIES(N_ENTRIES)) u_match (
    .ents(ents), .lk_va(lk_va), .lk_ctx(lk_ctx), .fl_op(op_e),
    .fl_va(fl_va), .fl_ctx(fl_ctx), .lk_vec(lk_vec), .fl_vec(fl_vec));

  ctx_tlb_pick #(.N_ENTRIES(N_ENTRIES)) u_pick (
    .vec(lk_vec), .any(lk_any), .idx(lk_slot));

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_vld
    assign valid_vec[g] = ents[g].valid;
  end

  assign ins_fire   = ins_valid && !fl_valid;
  assign hit_on_ptr = lk_valid && lk_any && (lk_slot == vptr);
  assign ptr_clr    = fl_valid && (op_e == FL_ALL);
  assign ptr_adv    = !fl_valid && (ins_fire || hit_on_ptr);

  ctx_tlb_victim #(.N_ENTRIES(N_ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .adv(ptr_adv), .ptr(vptr));

  always_comb begin
    new_ent         = '0;
    new_ent.valid   = 1'b1;
    new_ent.vpn     = ins_vpn;
    new_ent.size    = ins_size;
    new_ent.pfn     = ins_pfn;
    new_ent.asid    = ins_ctx;
    new_ent.dom     = ins_domain;
    new_ent.ap      = ins_ap;
    new_ent.xn      = ins_xn;
    new_ent.section = ins_section;
    new_ent.nc      = ins_nc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENTRIES; i++) ents[i] <= '0;
      fl_done <= 1'b0;
    end else begin
      fl_done <= fl_valid;
      if (fl_valid) begin
        for (int i = 0; i < N_ENTRIES; i++) begin
          if (fl_vec[i]) ents[i].valid <= 1'b0;
        end
      end else if (ins_fire) begin
        ents[vptr] <= new_ent;
      end
    end
  end

  assign sel        = ents[lk_slot];
  assign lk_hit     = lk_valid && lk_any;
  assign lk_pa      = xlate(sel, lk_va);
  assign lk_size    = sel.size;
  assign lk_domain  = sel.dom;
  assign lk_ap      = sel.ap;
  assign lk_xn      = sel.xn;
  assign lk_section = sel.section;
  assign lk_nc      = sel.nc;

  p_hit_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> valid_vec[lk_slot]);

  p_insert_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !fl_valid) |=> valid_vec[$past(vptr)]);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |=> fl_done);

  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_valid |=> !fl_done);

  p_flush_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && fl_op != 2'd0) |=> (vptr == $past(vptr)));

  p_flush_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && fl_op == 2'd0) |=> (valid_vec == '0 && vptr == '0));
endmodule

// File: tb/ctx_tlb_bench.sv
module ctx_tlb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int IW = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_hit, lk_xn, lk_section, lk_nc;
  logic [31:0] lk_va, lk_pa, fl_va;
  logic [7:0]  lk_ctx, ins_ctx, fl_ctx;
  logic [IW-1:0] lk_slot;
  logic [1:0]  lk_size, ins_size, fl_op;
  logic [3:0]  lk_domain, ins_domain;
  logic [2:0]  lk_ap, ins_ap;
  logic        ins_valid, ins_xn, ins_section, ins_nc, fl_valid, fl_done;
  logic [19:0] ins_vpn, ins_pfn;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_tlb #(.N_ENTRIES(N)) u_ctx_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_ctx(lk_ctx), .lk_hit(lk_hit),
    .lk_slot(lk_slot), .lk_pa(lk_pa), .lk_size(lk_size), .lk_domain(lk_domain),
    .lk_ap(lk_ap), .lk_xn(lk_xn), .lk_section(lk_section), .lk_nc(lk_nc),
    .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_ctx(ins_ctx), .ins_size(ins_size),
    .ins_pfn(ins_pfn), .ins_domain(ins_domain), .ins_ap(ins_ap), .ins_xn(ins_xn),
    .ins_section(ins_section), .ins_nc(ins_nc),
    .fl_valid(fl_valid), .fl_op(fl_op), .fl_va(fl_va), .fl_ctx(fl_ctx),
    .fl_done(fl_done));

  typedef struct {
    string       tag;
    bit          lk_chk;
    bit          exp_hit;
    logic [31:0] exp_pa;
    int          exp_slot;
    logic [3:0]  exp_dom;
    int          exp_sz;
    bit          exp_done;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;

  // reference model
  bit          m_v    [N];
  logic [31:0] m_base [N];
  int          m_sh   [N];
  int          m_sz   [N];
  logic [7:0]  m_asid [N];
  logic [19:0] m_pfn  [N];
  int          mptr = 0;
  bit          done_next = 0;

  function automatic bit m_in(int i, logic [31:0] va);
    return (m_base[i] >> m_sh[i]) == (va >> m_sh[i]);
  endfunction

  function automatic int m_find(logic [31:0] va, logic [7:0] ctx);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_asid[i] == ctx && m_in(i, va)) return i;
    return -1;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL [%s] %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: compares queued expectations a quarter period after the drive edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(fl_done == it.exp_done, it.tag, "R6 fl_done", 32'(fl_done), 32'(it.exp_done));
        if (it.lk_chk) begin
          check(lk_hit == it.exp_hit, it.tag, "lk_hit", 32'(lk_hit), 32'(it.exp_hit));
          if (it.exp_hit) begin
            check(int'(lk_slot) == it.exp_slot, it.tag, "lk_slot", 32'(lk_slot), 32'(it.exp_slot));
            check(lk_pa == it.exp_pa, it.tag, "lk_pa", lk_pa, it.exp_pa);
            check(lk_domain == it.exp_dom, it.tag, "lk_domain", 32'(lk_domain), 32'(it.exp_dom));
            check(int'(lk_size) == it.exp_sz, it.tag, "lk_size", 32'(lk_size), 32'(it.exp_sz));
          end
        end
      end
    end
  end

  // driver: one cycle of stimulus, expectation pushed, model advanced
  task automatic cyc(bit dl, logic [31:0] lva, logic [7:0] lctx,
                     bit di, logic [31:0] iva, logic [7:0] ictx, int isz, logic [19:0] ipfn,
                     bit df, int fop, logic [31:0] fva, logic [7:0] fctx, string tag);
    item_t it;
    int h;
    bit adv;
    @(negedge clk);
    lk_valid = dl;  lk_va = lva;  lk_ctx = lctx;
    ins_valid = di; ins_vpn = iva[31:12]; ins_ctx = ictx; ins_size = isz[1:0];
    ins_pfn = ipfn; ins_domain = ictx[3:0]; ins_ap = 3'd5; ins_xn = 1'b1;
    ins_section = isz[1]; ins_nc = 1'b0;
    fl_valid = df;  fl_op = fop[1:0]; fl_va = fva; fl_ctx = fctx;
    h = dl ? m_find(lva, lctx) : -1;
    it.tag = tag; it.lk_chk = dl; it.exp_done = done_next;
    it.exp_hit = (h >= 0); it.exp_slot = h; it.exp_pa = '0; it.exp_dom = '0; it.exp_sz = 0;
    if (h >= 0) begin
      logic [31:0] full;
      full = {m_pfn[h], 12'h000};
      it.exp_pa  = ((full >> m_sh[h]) << m_sh[h]) | (lva & ((32'h1 << m_sh[h]) - 1));
      it.exp_dom = m_asid[h][3:0];
      it.exp_sz  = m_sz[h];
    end
    q.push_back(it);
    done_next = df;
    if (df) begin
      for (int i = 0; i < N; i++) begin
        case (fop)
          0: m_v[i] = 0;
          1: if (m_asid[i] == fctx) m_v[i] = 0;
          2: if (m_in(i, fva)) m_v[i] = 0;
          default: if (m_asid[i] == fctx && m_in(i, fva)) m_v[i] = 0;
        endcase
      end
      if (fop == 0) mptr = 0;
    end else begin
      adv = (h >= 0 && h == mptr);
      if (di) begin
        m_v[mptr] = 1; m_base[mptr] = {iva[31:12], 12'h000}; m_sz[mptr] = isz;
        m_sh[mptr] = 12 + 4 * isz; m_asid[mptr] = ictx; m_pfn[mptr] = ipfn;
        adv = 1;
      end
      if (adv) mptr = (mptr + 1) % N;
    end
    @(posedge clk);
  endtask

  task automatic lk(logic [31:0] va, logic [7:0] ctx, string tag);
    cyc(1, va, ctx, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic ins(logic [31:0] va, logic [7:0] ctx, int sz, logic [19:0] pfn, string tag);
    cyc(0, 0, 0, 1, va, ctx, sz, pfn, 0, 0, 0, 0, tag);
  endtask
  task automatic fl(int op, logic [31:0] va, logic [7:0] ctx, string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, op, va, ctx, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired (all requirements): actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lk_valid = 0; lk_va = 0; lk_ctx = 0; ins_valid = 0; ins_vpn = 0; ins_ctx = 0;
    ins_size = 0; ins_pfn = 0; ins_domain = 0; ins_ap = 0; ins_xn = 0; ins_section = 0;
    ins_nc = 0; fl_valid = 0; fl_op = 0; fl_va = 0; fl_ctx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    lk(32'h0000_1000, 8'h11, "R11 reset miss");
    for (int i = 0; i < N; i++) ins(32'h0001_0000 + i * 32'h1000, 8'h11, 0, 20'h800 + 20'(i), "R4 fill");
    for (int i = 0; i < N; i++) lk(32'h0001_0234 + i * 32'h1000, 8'h11, "R1 R3 R4 slot lookup");
    lk(32'h0001_0000, 8'h22, "R1 tag mismatch");
    lk(32'h0009_0000, 8'h11, "R1 address miss");
    lk(32'h0001_0000, 8'h11, "R5 hit on pointed slot");
    ins(32'h000A_0000, 8'h11, 0, 20'h0A0, "R5 victim after hit");
    lk(32'h000A_0004, 8'h11, "R5 new entry slot");
    lk(32'h0001_1000, 8'h11, "R4 valid slot overwritten");
    cyc(1, 32'h0001_2000, 8'h11, 1, 32'h000B_0000, 8'h11, 0, 20'h0B0, 0, 0, 0, 0, "R5 hit plus insert");
    ins(32'h000C_0000, 8'h11, 0, 20'h0C0, "R5 single step");
    lk(32'h000C_0000, 8'h11, "R5 single step slot");

    fl(0, 0, 0, "R7 flush all");
    lk(32'h0001_4000, 8'h11, "R7 all invalid");
    ins(32'h5000_0000, 8'h11, 1, 20'h12345, "R7 pointer zero");
    ins(32'h6000_0000, 8'h11, 2, 20'hABCDE, "R3 1MiB");
    ins(32'h7000_0000, 8'h11, 3, 20'h55555, "R3 16MiB");
    lk(32'h5000_ABCD, 8'h11, "R3 R7 64KiB");
    lk(32'h600F_1234, 8'h11, "R3 1MiB stitch");
    lk(32'h70FE_DCBA, 8'h11, "R3 16MiB stitch");
    lk(32'h5001_0000, 8'h11, "R3 past 64KiB");
    ins(32'h6004_0000, 8'h11, 0, 20'h33333, "R2 overlap");
    lk(32'h6004_0010, 8'h11, "R2 lowest wins");

    cyc(0, 0, 0, 1, 32'h8000_0000, 8'h11, 0, 20'h08000, 1, 1, 0, 8'h99, "R6 flush beats insert");
    lk(32'h8000_0000, 8'h11, "R6 insert dropped");
    ins(32'h9000_0000, 8'h11, 0, 20'h09000, "R6 ptr held");
    lk(32'h9000_0000, 8'h11, "R6 ptr held slot");

    ins(32'hD000_0000, 8'h22, 0, 20'h0D000, "R8 setup");
    fl(1, 0, 8'h22, "R8 tag flush");
    lk(32'hD000_0000, 8'h22, "R8 tag gone");
    lk(32'h5000_0000, 8'h11, "R8 other tag kept");

    ins(32'hE000_0000, 8'h33, 2, 20'h0E000, "R9 setup");
    fl(2, 32'hE008_8000, 8'h00, "R9 range flush");
    lk(32'hE000_0000, 8'h33, "R9 any tag cleared");
    fl(2, 32'h6010_0000, 8'h00, "R9 end exclusive");
    lk(32'h6000_0000, 8'h11, "R9 page kept");

    ins(32'hF000_0000, 8'h44, 0, 20'h0F000, "R10 setup a");
    ins(32'hF000_0000, 8'h55, 0, 20'h0F001, "R10 setup b");
    fl(3, 32'hF000_0123, 8'h44, "R10 addr tag flush");
    lk(32'hF000_0000, 8'h44, "R10 match gone");
    lk(32'hF000_0000, 8'h55, "R10 other tag kept");
    ins(32'hF100_0000, 8'h44, 0, 20'h0F100, "R10 dup a");
    ins(32'hF100_0000, 8'h44, 0, 20'h0F101, "R10 dup b");
    fl(3, 32'hF100_0000, 8'h44, "R10 dup flush");
    lk(32'hF100_0000, 8'h44, "R10 duplicates gone");

    repeat (2) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 idle");
    @(negedge clk);
    #(CLK_PERIOD/2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule